// File: doc/BRIEF.md
# Dithered PLL Feedback Divider Controller

This block is the digital side of a frequency synthesizer's feedback path. It keeps the multiplication factor that sets the feedback divide ratio, a modulation divider, a peak-deviation setting and a dither-enable bit. When dither is off, the divide value presented to the loop is exactly the programmed factor. When dither is on, the divide value moves around the factor in a symmetric triangle. One full triangle lasts thirty-two steps, and each step lasts as many reference clocks as the modulation divider holds.

Software reaches the settings through a small write/read bus with a two-bit address. Each setting is protected by a mode guard. The factor can change only while the limp-mode input is high. The modulation divider and the peak deviation can change only while dither is off. Writes that carry an illegal value are refused, and they raise a sticky error flag. The reset value of the factor is chosen by the configuration inputs that are sampled during reset. All logic runs on the reference clock and uses a synchronous active-high reset.

Top module: `pll_div_ctrl`

## Requirements
- R1: In reset, the factor becomes 0x78 (120) when `cfg_en` and `cfg_sel` are both high, and 0x5A (90) otherwise. At the same time the modulation divider becomes 16, the peak becomes 4, dither and `err_o` become 0, and `div_o` becomes the reset factor.
- R2: A write to address 0 (factor) updates the factor only in a cycle where `limp` is high. In any other cycle it is ignored and does not set the error flag.
- R3: Only factor codes from 88 to 135 are accepted. A write of any other code while `limp` is high keeps the old factor and sets `err_o`. `err_o` stays high until reset.
- R4: A write to address 1 (modulation divider) is ignored while dither is enabled, and it then sets no error. While dither is disabled, a value outside the range 5 to 50 keeps the old divider and sets `err_o`.
- R5: Address 2 is control. Bit 0 is dither enable, and it is always writable. Address 3 is the 4-bit peak deviation in bits 3:0, and it is writable only while dither is disabled. Unused upper bits of both addresses read as zero.
- R6: Once dither has been disabled for two cycles, `div_o` equals the factor exactly, and the triangle phase is held at its midpoint (phase 8).
- R7: While dither is enabled, a 5-bit phase starts at 8 and advances by one every MODDIV clocks, so one triangle lasts 32×MODDIV clocks. From the phase p, a fold value t is formed: t = p when p < 16, and t = 32 − p otherwise. The raw offset is then t − 8.
- R8: The raw offset is clamped to ±min(peak, 8), and `div_o` equals the factor plus the clamped offset.
- R9: `bus_rdata` returns the register that `bus_addr` selected at the previous clock edge.
- R10: `div_o` is registered. It reflects the factor and phase that were held before the most recent edge, so a factor write and a phase step that land on the same edge both appear together one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Reset configuration enable, sampled during reset |
| cfg_sel | input | 1 | Alternate-factor selector, sampled during reset |
| limp | input | 1 | Limp mode; permits factor writes |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 factor, 1 modulation divider, 2 control, 3 peak) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| err_o | output | 1 | Sticky illegal-write flag |
| div_o | output | 8 | Instantaneous feedback divide value |

## Verification
Two functions can fall on the same clock edge: a factor write under limp mode and a triangle step boundary. The bench enables dither with a 6-clock step and times a factor write so that it lands on the edge where the phase first advances. One clock later, `div_o` must show the new factor plus the offset of the new phase. Every cycle of the sweep is compared with a closed-form triangle model, and the model switches factor exactly at the write edge.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
  typedef enum logic [1:0] {
    A_FACT = 2'd0,
    A_MDIV = 2'd1,
    A_CTRL = 2'd2,
    A_PEAK = 2'd3
  } reg_addr_e;

  localparam int PHASE_BITS = 5;
endpackage

// File: rtl/pll_div_regs.sv
module pll_div_regs
  import pll_div_pkg::*;
#(
  parameter int DW   = 8,
  parameter int PW   = 4,
  parameter int FMIN = 88,
  parameter int FMAX = 135,
  parameter int MMIN = 5,
  parameter int MMAX = 50,
  parameter int MRST = 16,
  parameter int PRST = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] rst_factor,
  input  logic          limp,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] factor_q,
  output logic [DW-1:0] moddiv_q,
  output logic [PW-1:0] peak_q,
  output logic          dith_q,
  output logic          err_q,
  output logic [DW-1:0] rdata_q
);
  logic [DW-1:0] rd_mux;
  logic          fact_ok;
  logic          mod_ok;

  always_comb begin
    case (reg_addr_e'(addr))
      A_FACT:  rd_mux = factor_q;
      A_MDIV:  rd_mux = moddiv_q;
      A_CTRL:  rd_mux = {{(DW-1){1'b0}}, dith_q};
      default: rd_mux = {{(DW-PW){1'b0}}, peak_q};
    endcase
  end

  assign fact_ok = (int'(wdata) >= FMIN) && (int'(wdata) <= FMAX);
  assign mod_ok  = (int'(wdata) >= MMIN) && (int'(wdata) <= MMAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      factor_q <= rst_factor;
      moddiv_q <= DW'(MRST);
      peak_q   <= PW'(PRST);
      dith_q   <= 1'b0;
      err_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rdata_q <= rd_mux;
      if (we) begin
        case (reg_addr_e'(addr))
          A_FACT: begin
            if (limp) begin
              if (fact_ok) factor_q <= wdata;
              else         err_q    <= 1'b1;
            end
          end
          A_MDIV: begin
            if (!dith_q) begin
              if (mod_ok) moddiv_q <= wdata;
              else        err_q    <= 1'b1;
            end
          end
          A_CTRL: dith_q <= wdata[0];
          default: begin
            if (!dith_q) peak_q <= wdata[PW-1:0];
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/pll_div_tri.sv
module pll_div_tri #(
  parameter int MW  = 8,
  parameter int PHW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic [MW-1:0]  moddiv,
  output logic [PHW-1:0] ph_q
);
  localparam int STEPS = 1 << PHW;
  localparam int MID   = STEPS / 4;

  logic [MW-1:0] cnt_q;
  logic          step;

  assign step = (cnt_q >= moddiv - MW'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      ph_q  <= PHW'(MID);
    end else if (step) begin
      cnt_q <= '0;
      ph_q  <= ph_q + PHW'(1);
    end else begin
      cnt_q <= cnt_q + MW'(1);
    end
  end
endmodule

// File: rtl/pll_div_mix.sv
module pll_div_mix #(
  parameter int DW  = 8,
  parameter int PW  = 4,
  parameter int PHW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [DW-1:0]  rst_val,
  input  logic [DW-1:0]  factor,
  input  logic [PHW-1:0] ph,
  input  logic [PW-1:0]  peak,
  output logic [DW-1:0]  div_q
);
  localparam int STEPS = 1 << PHW;
  localparam int HALF  = STEPS / 2;
  localparam int MID   = HALF / 2;

  int            fold;
  int            off;
  int            lim;
  logic [DW-1:0] div_n;

  always_comb begin
    fold = (int'(ph) < HALF) ? int'(ph) : (STEPS - int'(ph));
    lim  = (int'(peak) > MID) ? MID : int'(peak);
    off  = fold - MID;
    if (off > lim)  off = lim;
    if (off < -lim) off = -lim;
    div_n = DW'(int'(factor) + off);
  end

  always_ff @(posedge clk) begin
    if (rst) div_q <= rst_val;
    else     div_q <= div_n;
  end
endmodule

// File: rtl/pll_div_ctrl.sv
module pll_div_ctrl
  import pll_div_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          PW       = 4,
  parameter int          FMIN     = 88,
  parameter int          FMAX     = 135,
  parameter int          MMIN     = 5,
  parameter int          MMAX     = 50,
  parameter int          MRST     = 16,
  parameter int          PRST     = 4,
  parameter logic [7:0]  FRST_DEF = 8'h5A,
  parameter logic [7:0]  FRST_ALT = 8'h78
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_en,
  input  logic          cfg_sel,
  input  logic          limp,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          err_o,
  output logic [DW-1:0] div_o
);
  localparam int PHW = PHASE_BITS;

  logic [DW-1:0]  rst_factor;
  logic [DW-1:0]  factor_q;
  logic [DW-1:0]  moddiv_q;
  logic [PW-1:0]  peak_q;
  logic           dith_q;
  logic [PHW-1:0] ph_q;

  assign rst_factor = (cfg_en && cfg_sel) ? DW'(FRST_ALT) : DW'(FRST_DEF);

  pll_div_regs #(
    .DW(DW), .PW(PW), .FMIN(FMIN), .FMAX(FMAX),
    .MMIN(MMIN), .MMAX(MMAX), .MRST(MRST), .PRST(PRST)
  ) u_regs (
    .clk(clk), .rst(rst), .rst_factor(rst_factor), .limp(limp),
    .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .factor_q(factor_q), .moddiv_q(moddiv_q), .peak_q(peak_q),
    .dith_q(dith_q), .err_q(err_o), .rdata_q(bus_rdata)
  );

  pll_div_tri #(.MW(DW), .PHW(PHW)) u_tri (
    .clk(clk), .rst(rst), .run(dith_q), .moddiv(moddiv_q), .ph_q(ph_q)
  );

  pll_div_mix #(.DW(DW), .PW(PW), .PHW(PHW)) u_mix (
    .clk(clk), .rst(rst), .rst_val(rst_factor), .factor(factor_q),
    .ph(ph_q), .peak(peak_q), .div_q(div_o)
  );
endmodule

// File: rtl/pll_div_ctrl_chk.sv
module pll_div_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       limp,
  input logic       bus_we,
  input logic [1:0] bus_addr,
  input logic [7:0] factor_q,
  input logic [7:0] moddiv_q,
  input logic       dith_q,
  input logic [4:0] ph_q,
  input logic [7:0] div_o,
  input logic       err_o
);
  logic [1:0] cyc;
  logic       ok;

  always_ff @(posedge clk) begin
    if (rst)            cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end
  assign ok = (cyc == 2'd3);

  a_r2_limp_guard: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 2'd0 && !limp) |=> $stable(factor_q));

  a_r3_legal_factor: assert property (@(posedge clk) disable iff (rst)
    ok |-> (factor_q >= 8'd88 && factor_q <= 8'd135));

  a_r3_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

  a_r4_mdiv_block: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 2'd1 && dith_q) |=> $stable(moddiv_q));

  a_r6_nominal: assert property (@(posedge clk) disable iff (rst)
    (ok && !$past(dith_q) && !$past(dith_q, 2)) |-> (div_o == $past(factor_q)));

  a_r7_phase_step: assert property (@(posedge clk) disable iff (rst)
    (ok && ph_q != $past(ph_q)) |->
      ((ph_q == 5'($past(ph_q) + 5'd1)) || (ph_q == 5'd8 && !$past(dith_q))));

  a_r8_bound: assert property (@(posedge clk) disable iff (rst)
    ok |-> (({1'b0, div_o} + 9'd8 >= {1'b0, $past(factor_q)}) &&
            ({1'b0, div_o} <= {1'b0, $past(factor_q)} + 9'd8)));
endmodule

bind pll_div_ctrl pll_div_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .limp(limp), .bus_we(bus_we), .bus_addr(bus_addr),
  .factor_q(factor_q), .moddiv_q(moddiv_q), .dith_q(dith_q), .ph_q(ph_q),
  .div_o(div_o), .err_o(err_o)
);

// File: tb/sim_pll_div_ctrl.sv
`timescale 1ns/1ps
module sim_pll_div_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_en = 1'b0, cfg_sel = 1'b0, limp = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       err_o;
  logic [7:0] div_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pll_div_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_sel(cfg_sel), .limp(limp),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .err_o(err_o), .div_o(div_o)
  );

  // {limp, addr, wdata, expected readback, expected err}
  localparam logic [19:0] VEC [12] = '{
    {1'b0, 2'd0, 8'h64, 8'h5A, 1'b0},  // R2 ignored without limp
    {1'b1, 2'd0, 8'h64, 8'h64, 1'b0},  // R2 accepted in limp
    {1'b1, 2'd0, 8'h87, 8'h87, 1'b0},  // R3 upper legal
    {1'b1, 2'd0, 8'h58, 8'h58, 1'b0},  // R3 lower legal
    {1'b0, 2'd1, 8'h05, 8'h05, 1'b0},  // R4 min
    {1'b0, 2'd1, 8'h32, 8'h32, 1'b0},  // R4 max
    {1'b0, 2'd3, 8'hFF, 8'h0F, 1'b0},  // R5 upper bits zero
    {1'b0, 2'd3, 8'h06, 8'h06, 1'b0},  // R5
    {1'b0, 2'd2, 8'hFE, 8'h00, 1'b0},  // R5 control upper zero
    {1'b1, 2'd0, 8'h88, 8'h58, 1'b1},  // R3 reserved code
    {1'b0, 2'd1, 8'h33, 8'h32, 1'b1},  // R4 above range
    {1'b0, 2'd1, 8'h04, 8'h32, 1'b1}   // R4 below range
  };

  task automatic chk(input bit c, input string req, input int act, input int exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic do_reset(input logic en, input logic sel);
    @(negedge clk);
    rst = 1'b1; cfg_en = en; cfg_sel = sel; limp = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0; cfg_en = 1'b0; cfg_sel = 1'b0;
  endtask

  function automatic int expv(int n, int m, int pk, int f);
    int ph, t, o, lim;
    ph  = (8 + (n - 1) / m) % 32;
    t   = (ph < 16) ? ph : 32 - ph;
    o   = t - 8;
    lim = (pk > 8) ? 8 : pk;
    if (o > lim)  o = lim;
    if (o < -lim) o = -lim;
    return f + o;
  endfunction

  // Call right after the write that enables dither.
  task automatic sweep(input int ncyc, input int m, input int pk, input int f0,
                       input int inj, input logic [7:0] newf);
    for (int n = 1; n <= ncyc; n++) begin
      int f;
      if (n == inj) begin
        bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = newf;
      end
      @(negedge clk);
      bus_we = 1'b0;
      f = (inj > 0 && n > inj) ? int'(newf) : f0;
      chk(int'(div_o) == expv(n, m, pk, f), "R7/R8/R10 triangle", div_o, expv(n, m, pk, f));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    // R1 default reset
    do_reset(1'b0, 1'b0);
    chk(div_o == 8'h5A, "R1 div_o default", div_o, 8'h5A);
    chk(err_o == 1'b0, "R1 err", err_o, 0);
    rd(2'd0, d); chk(d == 8'h5A, "R1 factor", d, 8'h5A);
    rd(2'd1, d); chk(d == 8'd16, "R1 moddiv", d, 16);
    rd(2'd3, d); chk(d == 8'd4, "R1 peak", d, 4);
    rd(2'd2, d); chk(d == 8'd0, "R1 control", d, 0);

    // table walk: R2 R3 R4 R5 R9
    for (int i = 0; i < 12; i++) begin
      limp = VEC[i][19];
      wr(VEC[i][18:17], VEC[i][16:9]);
      limp = 1'b0;
      rd(VEC[i][18:17], d);
      chk(d == VEC[i][8:1], "R9 readback vector", d, VEC[i][8:1]);
      chk(err_o == VEC[i][0], "R3/R4 err vector", err_o, VEC[i][0]);
    end

    // R1 configuration-selected reset values
    do_reset(1'b1, 1'b1);
    chk(div_o == 8'h78, "R1 alt div_o", div_o, 8'h78);
    chk(err_o == 1'b0, "R1 err cleared", err_o, 0);
    rd(2'd0, d); chk(d == 8'h78, "R1 alt factor", d, 8'h78);
    do_reset(1'b1, 1'b0);
    rd(2'd0, d); chk(d == 8'h5A, "R1 en without sel", d, 8'h5A);

    // R7 R8 dither sweep, peak 3, step 5 clocks, two periods
    do_reset(1'b0, 1'b0);
    wr(2'd1, 8'd5);
    wr(2'd3, 8'd3);
    wr(2'd2, 8'd1);
    sweep(320, 5, 3, 90, 0, 8'h00);
    // R4 R5 guards while dithering
    wr(2'd1, 8'd20);
    rd(2'd1, d); chk(d == 8'd5, "R4 blocked while dither", d, 5);
    chk(err_o == 1'b0, "R4 blocked sets no err", err_o, 0);
    wr(2'd3, 8'd9);
    rd(2'd3, d); chk(d == 8'd3, "R5 peak blocked while dither", d, 3);
    rd(2'd2, d); chk(d == 8'd1, "R5 control bit", d, 1);
    // R6 back to nominal
    wr(2'd2, 8'd0);
    @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(div_o == 8'd90, "R6 nominal after disable", div_o, 90);
    end

    // R8 clamp at 8 with peak 12, R10 factor write on step edge
    wr(2'd3, 8'd12);
    wr(2'd1, 8'd6);
    limp = 1'b1;
    wr(2'd2, 8'd1);
    sweep(192, 6, 12, 90, 6, 8'h80);
    limp = 1'b0;
    wr(2'd2, 8'd0);
    rd(2'd0, d); chk(d == 8'h80, "R10 factor after concurrent write", d, 8'h80);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule